// File: doc/BRIEF.md
# Dual-Output Boost Loop Controller

This block is the digital mode and protection controller for one shared boost converter that feeds two outputs: a channel held at a fixed voltage and a channel that sinks a regulated current. Two enables pick the operating mode. The block decides whether the boost may switch, whether it is in its soft-start ramp, how each channel's pass switch is driven (off, fully on, or as a linear regulator), and which channel's error signal closes the boost loop.

When both channels run, the loop goes to whichever channel is falling short. A channel that reports less than 95 percent of its target for long enough takes the loop and drives its switch fully on. The other channel's switch then regulates linearly. Undervoltage and over-temperature shut everything down and restart the soft-start ramp once they clear. Overvoltage on the boost output only stops switching while it lasts.

Top module: `dual_boost_ctl`

## Requirements
- R1: When both enables are low, the next clock edge gives boost_en_o=0, ss_active_o=0, both switch modes 0 (off) and owner_o=0 (none). Switch mode codes are 0 off, 1 fully on, 2 linear. Owner codes are 0 none, 1 voltage channel, 2 current channel.
- R2: With only the current-channel enable high, the boost runs, owner_o=2, the current-channel switch is 1 and the voltage-channel switch is 0.
- R3: With only the voltage-channel enable high, the boost runs, owner_o=1, the voltage-channel switch is 1 and the current-channel switch is 0.
- R4: When both enables are high on leaving shutdown, both channels turn on at the same edge. The loop goes to the voltage channel if prefer_volt_i=1 and to the current channel if it is 0. The owner's switch is 1 and the other switch is 2. The two switches are never both 1.
- R5: While both channels run, a channel whose below-target flag stays high for 4 consecutive clock edges, while the other channel's flag is low, takes the loop at the 5th edge: its switch goes to 1 and the other switch goes to 2. A flag that is high for fewer than 4 edges changes nothing.
- R6: On leaving shutdown, ss_active_o is high for exactly SS_CYCLES clock cycles with boost_en_o high, then drops for normal regulation.
- R7: A temperature code of 160 or more shuts the block down (outputs as in R1) on the second edge. It comes back only once the code is 150 or less; codes 151 to 159 keep the state it is in.
- R8: While ovp_i is high, boost_en_o is low in the same cycle. The switch modes, the owner and the soft-start state are held.
- R9: Undervoltage or over-temperature forces the outputs of R1. When the fault clears with an enable high, soft start restarts and the loop owner is chosen again as in R2 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_volt_i | input | 1 | Enable for the fixed-voltage channel |
| en_curr_i | input | 1 | Enable for the current channel, already filtered by the shutdown delay |
| uv_i | input | 1 | Supply undervoltage flag |
| temp_i | input | 8 | Die temperature code |
| ovp_i | input | 1 | Boost output overvoltage flag |
| volt_low_i | input | 1 | Voltage channel below 95 percent of target |
| curr_low_i | input | 1 | Current channel below 95 percent of target |
| prefer_volt_i | input | 1 | Voltage channel needs the higher boost voltage; read on leaving shutdown |
| boost_en_o | output | 1 | Boost converter may switch |
| ss_active_o | output | 1 | Soft-start ramp in progress |
| sw_volt_o | output | 2 | Voltage-channel pass switch mode |
| sw_curr_o | output | 2 | Current-channel sink switch mode |
| owner_o | output | 2 | Channel that closes the boost loop |

## Verification
A loop handoff and a fault can land on the same clock edge. To provoke this, the current channel's below-target flag is held for four edges while the voltage channel owns the loop, and undervoltage rises just before the edge at which the handoff would take effect. The fault must win: that edge gives full shutdown with no owner. When the fault clears, the owner must come from prefer_volt_i rather than from the stale flag, and soft start must restart. Overvoltage is also raised while both channels run, to check that it gates switching in the same cycle without disturbing the owner or the switch modes.

// File: rtl/boost_ctl_pkg.sv
package boost_ctl_pkg;
  typedef enum logic [1:0] {
    SW_OFF  = 2'd0,
    SW_FULL = 2'd1,
    SW_LIN  = 2'd2
  } sw_mode_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_VOLT = 2'd1,
    OWN_CURR = 2'd2
  } owner_e;

  typedef enum logic [1:0] {
    ST_SHUT = 2'd0,
    ST_SOFT = 2'd1,
    ST_RUN  = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/thermal_guard.sv
module thermal_guard #(
  parameter int TEMP_W = 8,
  parameter int TRIP   = 160,
  parameter int HYST   = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              uv_i,
  output logic              fault_o
);
  localparam logic [TEMP_W-1:0] TRIP_C  = TEMP_W'(TRIP);
  localparam logic [TEMP_W-1:0] CLEAR_C = TEMP_W'(TRIP - HYST);

  logic hot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                hot_q <= 1'b0;
    else if (temp_i >= TRIP_C)  hot_q <= 1'b1;
    else if (temp_i <= CLEAR_C) hot_q <= 1'b0;
  end

  assign fault_o = hot_q | uv_i;

  // R7
  hot_trip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= TRIP_C) |=> hot_q);

  // R7
  hot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_q && temp_i > CLEAR_C) |=> hot_q);
endmodule

// File: rtl/low_persist.sv
module low_persist #(
  parameter int PERSIST = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flag_i,
  output logic qual_o
);
  localparam int            CW     = $clog2(PERSIST + 1);
  localparam logic [CW-1:0] FULL_C = CW'(PERSIST);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!flag_i)         cnt_q <= '0;
    else if (cnt_q != FULL_C) cnt_q <= cnt_q + CW'(1);
  end

  assign qual_o = (cnt_q == FULL_C);

  // R5
  qual_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_o |-> $past(flag_i));
endmodule

// File: rtl/pwr_seq.sv
module pwr_seq
  import boost_ctl_pkg::*;
#(
  parameter int SS_CYCLES = 500000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  output pwr_state_e state_o,
  output logic       enter_o
);
  localparam int            CW     = $clog2(SS_CYCLES + 1);
  localparam logic [CW-1:0] LAST_C = CW'(SS_CYCLES - 1);

  pwr_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!run_i) begin
      state_d = ST_SHUT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_SHUT: begin
          state_d = ST_SOFT;
          cnt_d   = '0;
        end
        ST_SOFT: begin
          if (cnt_q == LAST_C) state_d = ST_RUN;
          else                 cnt_d   = cnt_q + CW'(1);
        end
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SHUT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign enter_o = run_i && (state_q == ST_SHUT);

  // R6
  soft_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SOFT && cnt_q != LAST_C && run_i) |=> state_q == ST_SOFT);

  // R9
  fault_shut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> state_q == ST_SHUT);
endmodule

// File: rtl/loop_arbiter.sv
module loop_arbiter
  import boost_ctl_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   run_i,
  input  logic   enter_i,
  input  logic   en_volt_i,
  input  logic   en_curr_i,
  input  logic   prefer_volt_i,
  input  logic   volt_qual_i,
  input  logic   curr_qual_i,
  output owner_e owner_o
);
  owner_e owner_q, owner_d;

  always_comb begin
    owner_d = owner_q;
    if (!run_i)                                   owner_d = OWN_NONE;
    else if (en_volt_i && !en_curr_i)             owner_d = OWN_VOLT;
    else if (en_curr_i && !en_volt_i)             owner_d = OWN_CURR;
    else if (enter_i || owner_q == OWN_NONE)      owner_d = prefer_volt_i ? OWN_VOLT : OWN_CURR;
    else if (volt_qual_i && !curr_qual_i)         owner_d = OWN_VOLT;
    else if (curr_qual_i && !volt_qual_i)         owner_d = OWN_CURR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owner_q <= OWN_NONE;
    else         owner_q <= owner_d;
  end

  assign owner_o = owner_q;

  // R5
  handoff_volt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !enter_i && en_volt_i && en_curr_i && owner_q != OWN_NONE &&
     volt_qual_i && !curr_qual_i) |=> owner_q == OWN_VOLT);

  // R5
  handoff_curr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !enter_i && en_volt_i && en_curr_i && owner_q != OWN_NONE &&
     curr_qual_i && !volt_qual_i) |=> owner_q == OWN_CURR);
endmodule

// File: rtl/dual_boost_ctl.sv
module dual_boost_ctl
  import boost_ctl_pkg::*;
#(
  parameter int TEMP_W    = 8,
  parameter int TEMP_TRIP = 160,
  parameter int TEMP_HYST = 10,
  parameter int SS_CYCLES = 500000,
  parameter int PERSIST   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_volt_i,
  input  logic              en_curr_i,
  input  logic              uv_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              ovp_i,
  input  logic              volt_low_i,
  input  logic              curr_low_i,
  input  logic              prefer_volt_i,
  output logic              boost_en_o,
  output logic              ss_active_o,
  output logic [1:0]        sw_volt_o,
  output logic [1:0]        sw_curr_o,
  output logic [1:0]        owner_o
);
  localparam int NCH = 2;

  logic           fault, run, enter, active;
  logic [NCH-1:0] low_raw, low_qual;
  logic           en_volt_q, en_curr_q;
  pwr_state_e     state;
  owner_e         owner;
  sw_mode_e       sw_volt, sw_curr;

  thermal_guard #(
    .TEMP_W (TEMP_W),
    .TRIP   (TEMP_TRIP),
    .HYST   (TEMP_HYST)
  ) u_thermal (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .temp_i  (temp_i),
    .uv_i    (uv_i),
    .fault_o (fault)
  );

  assign run = (en_volt_i | en_curr_i) & ~fault;

  pwr_seq #(.SS_CYCLES(SS_CYCLES)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .state_o (state),
    .enter_o (enter)
  );

  assign low_raw = {curr_low_i, volt_low_i};

  for (genvar g = 0; g < NCH; g++) begin : g_persist
    low_persist #(.PERSIST(PERSIST)) u_persist (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flag_i (low_raw[g]),
      .qual_o (low_qual[g])
    );
  end

  loop_arbiter u_arb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_i         (run),
    .enter_i       (enter),
    .en_volt_i     (en_volt_i),
    .en_curr_i     (en_curr_i),
    .prefer_volt_i (prefer_volt_i),
    .volt_qual_i   (low_qual[0]),
    .curr_qual_i   (low_qual[1]),
    .owner_o       (owner)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_volt_q <= 1'b0;
      en_curr_q <= 1'b0;
    end else begin
      en_volt_q <= en_volt_i;
      en_curr_q <= en_curr_i;
    end
  end

  assign active = (state != ST_SHUT);

  always_comb begin
    sw_volt = SW_OFF;
    sw_curr = SW_OFF;
    if (active) begin
      unique case (owner)
        OWN_VOLT: begin
          sw_volt = SW_FULL;
          sw_curr = en_curr_q ? SW_LIN : SW_OFF;
        end
        OWN_CURR: begin
          sw_curr = SW_FULL;
          sw_volt = en_volt_q ? SW_LIN : SW_OFF;
        end
        default: ;
      endcase
    end
  end

  assign boost_en_o  = active & ~ovp_i;
  assign ss_active_o = (state == ST_SOFT);
  assign sw_volt_o   = sw_volt;
  assign sw_curr_o   = sw_curr;
  assign owner_o     = owner;

  // R1
  shutdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_volt_i && !en_curr_i) |=>
      (!boost_en_o && !ss_active_o && sw_volt_o == 2'd0 &&
       sw_curr_o == 2'd0 && owner_o == 2'd0));

  // R4
  no_dual_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_volt_o == 2'd1 && sw_curr_o == 2'd1));
endmodule

// File: tb/tb_dual_boost_ctl.sv
module tb_dual_boost_ctl;
  localparam int SS = 20;

  logic       clk = 1'b0;
  logic       rst_ni;
  logic       en_volt, en_curr, uv, ovp, volt_low, curr_low, prefer;
  logic [7:0] temp;
  logic       boost_en, ss_active;
  logic [1:0] sw_volt, sw_curr, owner;

  always #2 clk = ~clk;

  dual_boost_ctl #(.SS_CYCLES(SS)) dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .en_volt_i     (en_volt),
    .en_curr_i     (en_curr),
    .uv_i          (uv),
    .temp_i        (temp),
    .ovp_i         (ovp),
    .volt_low_i    (volt_low),
    .curr_low_i    (curr_low),
    .prefer_volt_i (prefer),
    .boost_en_o    (boost_en),
    .ss_active_o   (ss_active),
    .sw_volt_o     (sw_volt),
    .sw_curr_o     (sw_curr),
    .owner_o       (owner)
  );

  typedef struct packed {
    logic       b;
    logic       s;
    logic [1:0] v;
    logic [1:0] c;
    logic [1:0] o;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  task automatic expect_o(input logic b, input logic s, input logic [1:0] v,
                          input logic [1:0] c, input logic [1:0] o, input string tag);
    exp_t e;
    e = '{b: b, s: s, v: v, c: c, o: o};
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
  endtask

  // monitor: compares 1 ns after each rising edge
  initial begin
    forever begin
      exp_t  e;
      exp_t  a;
      string t;
      @(posedge clk);
      #1;
      while (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = '{b: boost_en, s: ss_active, v: sw_volt, c: sw_curr, o: owner};
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: got boost=%0d ss=%0d swv=%0d swc=%0d own=%0d, exp boost=%0d ss=%0d swv=%0d swc=%0d own=%0d",
                   t, a.b, a.s, a.v, a.c, a.o, e.b, e.s, e.v, e.c, e.o);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; en_volt = 0; en_curr = 0; uv = 0; ovp = 0;
    volt_low = 0; curr_low = 0; prefer = 0; temp = 8'd25;
    step(3);
    @(negedge clk) rst_ni = 1'b1;
    step(1); expect_o(0, 0, 0, 0, 0, "R1");

    // voltage channel alone, soft start length
    @(negedge clk) en_volt = 1;
    step(1);      expect_o(1, 1, 1, 0, 1, "R3");
    step(SS - 1); expect_o(1, 1, 1, 0, 1, "R6");
    step(1);      expect_o(1, 0, 1, 0, 1, "R6");
    @(negedge clk) en_volt = 0;
    step(1);      expect_o(0, 0, 0, 0, 0, "R1");

    // current channel alone
    @(negedge clk) en_curr = 1;
    step(1);      expect_o(1, 1, 0, 1, 2, "R2");
    @(negedge clk) en_curr = 0;
    step(1);      expect_o(0, 0, 0, 0, 0, "R1");

    // both, initial owner from prefer input
    @(negedge clk) begin prefer = 1; en_volt = 1; en_curr = 1; end
    step(1);      expect_o(1, 1, 1, 2, 1, "R4");
    @(negedge clk) begin en_volt = 0; en_curr = 0; end
    step(1);      expect_o(0, 0, 0, 0, 0, "R1");
    @(negedge clk) begin prefer = 0; en_volt = 1; en_curr = 1; end
    step(1);      expect_o(1, 1, 2, 1, 2, "R4");
    step(SS);     expect_o(1, 0, 2, 1, 2, "R6");

    // handoff needs 4 edges of the flag
    @(negedge clk) volt_low = 1;
    step(4);      expect_o(1, 0, 2, 1, 2, "R5");
    step(1);      expect_o(1, 0, 1, 2, 1, "R5");
    @(negedge clk) begin volt_low = 0; curr_low = 1; end
    step(3);
    @(negedge clk) curr_low = 0;
    step(3);      expect_o(1, 0, 1, 2, 1, "R5");

    // overvoltage gates switching only
    @(negedge clk) ovp = 1;
    step(1);      expect_o(0, 0, 1, 2, 1, "R8");
    @(negedge clk) ovp = 0;
    step(1);      expect_o(1, 0, 1, 2, 1, "R8");

    // thermal hysteresis
    @(negedge clk) temp = 8'd155;
    step(2);      expect_o(1, 0, 1, 2, 1, "R7");
    @(negedge clk) temp = 8'd160;
    step(1);      expect_o(1, 0, 1, 2, 1, "R7");
    step(1);      expect_o(0, 0, 0, 0, 0, "R7");
    @(negedge clk) temp = 8'd151;
    step(2);      expect_o(0, 0, 0, 0, 0, "R7");
    @(negedge clk) begin temp = 8'd150; prefer = 1; end
    step(1);      expect_o(0, 0, 0, 0, 0, "R7");
    step(1);      expect_o(1, 1, 1, 2, 1, "R9");
    step(SS);     expect_o(1, 0, 1, 2, 1, "R9");

    // undervoltage on the handoff edge
    @(negedge clk) curr_low = 1;
    step(4);
    @(negedge clk) uv = 1;
    step(1);      expect_o(0, 0, 0, 0, 0, "R9");
    @(negedge clk) begin uv = 0; curr_low = 0; end
    step(1);      expect_o(1, 1, 1, 2, 1, "R9");

    step(2);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule